// File: doc/BRIEF.md
# Windowed Readout Address Sequencer

This block walks the read addresses of a 1280 x 1024 pixel array, visiting only pixels that lie inside up to eight programmable rectangles. Columns are addressed in groups of eight pixels (160 groups per row), because eight pixels leave the array in parallel on each column step. Rows and column groups can be thinned by reading one and skipping one, or reading two and skipping two.

Settings arrive through a plain register write port and land in a shadow bank. A start pulse copies the shadow bank (windows, thinning mode, gain) into the active bank and begins a scan, so a frame always runs with one consistent set. The scan produces a row address, a column-group address and a read strobe, framed by one-cycle frame-start, line-start, line-end and frame-end markers. A busy flag covers the whole scan.

Top module: `roi_read_seq`

## Requirements
- R1: After reset, busy_o, rd_o and all four markers are low and gain_o is 0.
- R2: Write map: wr_addr_i[5]=0 selects window wr_addr_i[4:2] and field wr_addr_i[1:0]: field 0 sets first group [7:0] and last group [15:8]; field 1 sets first row [9:0] and last row [25:16]; field 2 sets the enable from bit 0; field 3 is ignored. wr_addr_i[5]=1 sets thinning mode from [1:0] (0 full, 1 read-1-skip-1, 2 read-2-skip-2, 3 behaves as 0) and gain from [11:8]. All bounds are inclusive.
- R3: A start_i sampled high while idle raises frame_start_o for the next cycle; busy_o is high from that cycle through the frame_end_o cycle and low on the cycle after.
- R4: Read rows are visited in ascending order; each is bracketed by a line_start_o cycle and a line_end_o cycle carrying its row on row_o, and between them rd_o strobes each read group once in ascending col_o order.
- R5: Where windows share rows, each row is read once and its groups are the union of the windows that cover that row.
- R6: In read-1-skip-1 only rows and groups whose bit 0 is 0 are read; in read-2-skip-2 only those whose bit 1 is 0 (steps +1, +3 from even values).
- R7: A window takes part only if enabled, first group <= last group, first row <= last row and last group < 160; any other window contributes nothing.
- R8: With no window taking part, frame_end_o follows frame_start_o on the very next cycle with no lines.
- R9: Writes reach the scan and gain_o only at the next accepted start; during a frame gain_o and the scan pattern stay fixed.
- R10: start_i while busy is ignored: no second frame follows.
- R11: At most one of rd_o and the four markers is high in any cycle, and only while busy_o is high.
- R12: Row 1023 and group 159 are reachable and read when covered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register address |
| wr_data_i | input | 32 | Register write data |
| start_i | input | 1 | Begin a frame scan |
| busy_o | output | 1 | Scan in progress |
| row_o | output | 10 | Current row address |
| col_o | output | 8 | Current column-group address |
| rd_o | output | 1 | Read strobe for row_o/col_o |
| frame_start_o | output | 1 | Frame start marker |
| line_start_o | output | 1 | Line start marker |
| line_end_o | output | 1 | Line end marker |
| frame_end_o | output | 1 | Frame end marker |
| gain_o | output | 4 | Gain of the active bank |

## Verification
A wrong row or column counter shows at once as a read strobe at an address the model did not predict, or as a line marker with the wrong row, on the same cycle the event is emitted. A corrupted coverage or thinning decision shows as a missing or extra strobe within the affected line, and a wrong end bound shows as a frame-end marker arriving early or a frame that runs past the model's last event. Leaks from the shadow bank appear as a changed gain_o or a changed pattern in the frame that was already running.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int unsigned ARR_COLS = 1280;
  localparam int unsigned ARR_ROWS = 1024;
  localparam int unsigned COL_GRP  = 8;
  localparam int unsigned WIN_N    = 8;
  localparam int unsigned GRP_N    = ARR_COLS / COL_GRP;
  localparam int unsigned RW       = $clog2(ARR_ROWS);
  localparam int unsigned CW       = $clog2(GRP_N);

  typedef struct packed {
    logic          en;
    logic [CW-1:0] xs;
    logic [CW-1:0] xe;
    logic [RW-1:0] ys;
    logic [RW-1:0] ye;
  } win_t;

  typedef enum logic [1:0] {
    SUB_FULL = 2'd0,
    SUB_1S1  = 2'd1,
    SUB_2S2  = 2'd2,
    SUB_RSV  = 2'd3
  } sub_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FS, ST_ROW, ST_LS, ST_COL, ST_LE, ST_FE
  } st_e;

  function automatic logic keep(sub_e m, logic [1:0] lsb);
    case (m)
      SUB_1S1: keep = ~lsb[0];
      SUB_2S2: keep = ~lsb[1];
      default: keep = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/rrs_regs.sv
module rrs_regs
  import rrs_pkg::*;
#(
  parameter int unsigned NWIN = WIN_N,
  parameter int unsigned GW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [5:0]    wr_addr_i,
  input  logic [31:0]   wr_data_i,
  input  logic          load_i,
  output win_t          act_o [NWIN],
  output sub_e          sub_o,
  output logic [GW-1:0] gain_o
);
  win_t          sh_q [NWIN];
  sub_e          sub_sh_q;
  logic [GW-1:0] gain_sh_q;
  logic          unused_data;

  assign unused_data = ^wr_data_i;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q[i]  <= '0;
        act_o[i] <= '0;
      end else begin
        if (wr_en_i && !wr_addr_i[5] && (int'(wr_addr_i[4:2]) == i)) begin
          case (wr_addr_i[1:0])
            2'd0: begin
              sh_q[i].xs <= wr_data_i[CW-1:0];
              sh_q[i].xe <= wr_data_i[8 +: CW];
            end
            2'd1: begin
              sh_q[i].ys <= wr_data_i[RW-1:0];
              sh_q[i].ye <= wr_data_i[16 +: RW];
            end
            2'd2:    sh_q[i].en <= wr_data_i[0];
            default: ;
          endcase
        end
        if (load_i) act_o[i] <= sh_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_sh_q  <= SUB_FULL;
      gain_sh_q <= '0;
      sub_o     <= SUB_FULL;
      gain_o    <= '0;
    end else begin
      if (wr_en_i && wr_addr_i[5]) begin
        sub_sh_q  <= sub_e'(wr_data_i[1:0]);
        gain_sh_q <= wr_data_i[8 +: GW];
      end
      if (load_i) begin
        sub_o  <= sub_sh_q;
        gain_o <= gain_sh_q;
      end
    end
  end

  // R9: active bank moves only on a load
  a_r9_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(gain_o) && $stable(sub_o));
endmodule

// File: rtl/rrs_cover.sv
module rrs_cover
  import rrs_pkg::*;
#(
  parameter int unsigned NWIN = WIN_N
) (
  input  win_t          act_i [NWIN],
  input  logic [RW-1:0] row_i,
  input  logic [CW-1:0] col_i,
  output logic          any_live_o,
  output logic          row_hit_o,
  output logic          col_hit_o,
  output logic [RW-1:0] row_lo_o,
  output logic [RW-1:0] row_hi_o,
  output logic [CW-1:0] col_lo_o,
  output logic [CW-1:0] col_hi_o
);
  logic [NWIN-1:0] live, cov_r, cov_c;

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    assign live[i]  = act_i[i].en && (act_i[i].xs <= act_i[i].xe) &&
                      (act_i[i].ys <= act_i[i].ye) &&
                      (act_i[i].xe < CW'(GRP_N));
    assign cov_r[i] = live[i] && (row_i >= act_i[i].ys) && (row_i <= act_i[i].ye);
    assign cov_c[i] = cov_r[i] && (col_i >= act_i[i].xs) && (col_i <= act_i[i].xe);
  end

  always_comb begin
    any_live_o = |live;
    row_hit_o  = |cov_r;
    col_hit_o  = |cov_c;
    row_lo_o   = '1;
    row_hi_o   = '0;
    col_lo_o   = '1;
    col_hi_o   = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (live[i]) begin
        if (act_i[i].ys < row_lo_o) row_lo_o = act_i[i].ys;
        if (act_i[i].ye > row_hi_o) row_hi_o = act_i[i].ye;
      end
      if (cov_r[i]) begin
        if (act_i[i].xs < col_lo_o) col_lo_o = act_i[i].xs;
        if (act_i[i].xe > col_hi_o) col_hi_o = act_i[i].xe;
      end
    end
  end
endmodule

// File: rtl/rrs_scan.sv
module rrs_scan
  import rrs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  sub_e          sub_i,
  input  logic          any_live_i,
  input  logic          row_hit_i,
  input  logic          col_hit_i,
  input  logic [RW-1:0] row_lo_i,
  input  logic [RW-1:0] row_hi_i,
  input  logic [CW-1:0] col_lo_i,
  input  logic [CW-1:0] col_hi_i,
  output logic          load_o,
  output logic          busy_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          rd_o,
  output logic          fs_o,
  output logic          ls_o,
  output logic          le_o,
  output logic          fe_o
);
  st_e           st_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          row_keep, col_keep;

  assign row_keep = keep(sub_i, row_q[1:0]);
  assign col_keep = keep(sub_i, col_q[1:0]);
  assign load_o   = (st_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      row_q <= '0;
      col_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_FS;
        ST_FS: begin
          row_q <= row_lo_i;
          st_q  <= any_live_i ? ST_ROW : ST_FE;
        end
        ST_ROW: begin
          if (row_hit_i && row_keep) begin
            col_q <= col_lo_i;
            st_q  <= ST_LS;
          end else if (row_q >= row_hi_i) begin
            st_q <= ST_FE;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        ST_LS: st_q <= ST_COL;
        ST_COL: begin
          if (col_q >= col_hi_i) st_q <= ST_LE;
          else                   col_q <= col_q + 1'b1;
        end
        ST_LE: begin
          if (row_q >= row_hi_i) st_q <= ST_FE;
          else begin
            row_q <= row_q + 1'b1;
            st_q  <= ST_ROW;
          end
        end
        ST_FE:   st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign row_o  = row_q;
  assign col_o  = col_q;
  assign rd_o   = (st_q == ST_COL) && col_hit_i && col_keep;
  assign fs_o   = (st_q == ST_FS);
  assign ls_o   = (st_q == ST_LS);
  assign le_o   = (st_q == ST_LE);
  assign fe_o   = (st_q == ST_FE);

  a_r11_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_o, fs_o, ls_o, le_o, fe_o}));
  a_r11_event_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || fs_o || ls_o || le_o || fe_o) |-> busy_o);
  a_r4_rd_covered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> row_hit_i && col_hit_i);
  a_r8_empty_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_o && !any_live_i |=> fe_o);
  a_r10_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_o |=> !fs_o && busy_o);
  a_r4_line_bracket: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_o |=> !fe_o && !ls_o && !le_o);
endmodule

// File: rtl/roi_read_seq.sv
module roi_read_seq
  import rrs_pkg::*;
#(
  parameter int unsigned NWIN = WIN_N,
  parameter int unsigned GW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [5:0]    wr_addr_i,
  input  logic [31:0]   wr_data_i,
  input  logic          start_i,
  output logic          busy_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          rd_o,
  output logic          frame_start_o,
  output logic          line_start_o,
  output logic          line_end_o,
  output logic          frame_end_o,
  output logic [GW-1:0] gain_o
);
  win_t          act [NWIN];
  sub_e          sub;
  logic          load;
  logic          any_live, row_hit, col_hit;
  logic [RW-1:0] row_lo, row_hi;
  logic [CW-1:0] col_lo, col_hi;

  rrs_regs #(.NWIN(NWIN), .GW(GW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i (load),
    .act_o  (act),
    .sub_o  (sub),
    .gain_o (gain_o)
  );

  rrs_cover #(.NWIN(NWIN)) u_cover (
    .act_i      (act),
    .row_i      (row_o),
    .col_i      (col_o),
    .any_live_o (any_live),
    .row_hit_o  (row_hit),
    .col_hit_o  (col_hit),
    .row_lo_o   (row_lo),
    .row_hi_o   (row_hi),
    .col_lo_o   (col_lo),
    .col_hi_o   (col_hi)
  );

  rrs_scan u_scan (
    .clk_i, .rst_ni, .start_i,
    .sub_i      (sub),
    .any_live_i (any_live),
    .row_hit_i  (row_hit),
    .col_hit_i  (col_hit),
    .row_lo_i   (row_lo),
    .row_hi_i   (row_hi),
    .col_lo_i   (col_lo),
    .col_hi_i   (col_hi),
    .load_o     (load),
    .busy_o     (busy_o),
    .row_o      (row_o),
    .col_o      (col_o),
    .rd_o       (rd_o),
    .fs_o       (frame_start_o),
    .ls_o       (line_start_o),
    .le_o       (line_end_o),
    .fe_o       (frame_end_o)
  );

  a_r9_gain_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(gain_o));
  a_r3_busy_ends_on_fe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(frame_end_o));
  a_r3_fs_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> frame_start_o);
endmodule

// File: tb/roi_read_seq_tb.sv
`timescale 1ns/1ps
module roi_read_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        start_i = 1'b0;
  logic        busy_o, rd_o, frame_start_o, line_start_o, line_end_o, frame_end_o;
  logic [9:0]  row_o;
  logic [7:0]  col_o;
  logic [3:0]  gain_o;

  always #10 clk_i = ~clk_i;

  roi_read_seq u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .start_i,
    .busy_o, .row_o, .col_o, .rd_o, .frame_start_o, .line_start_o,
    .line_end_o, .frame_end_o, .gain_o
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit [20:0] exp_q [$];

  // bench copies of shadow and active settings
  int sh_en[8], sh_xs[8], sh_xe[8], sh_ys[8], sh_ye[8], sh_sub = 0, sh_gain = 0;
  int ac_en[8], ac_xs[8], ac_xe[8], ac_ys[8], ac_ye[8], ac_sub = 0, ac_gain = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [20:0] mk(int k, int r, int c);
    return {3'(k), 10'(r), 8'(c)};
  endfunction

  function automatic bit kp(int m, int v);
    if (m == 1) return (v % 2) == 0;
    if (m == 2) return ((v / 2) % 2) == 0;
    return 1'b1;
  endfunction

  function automatic bit live(int w);
    return ac_en[w] != 0 && ac_xs[w] <= ac_xe[w] && ac_ys[w] <= ac_ye[w] && ac_xe[w] < 160;
  endfunction

  task automatic build_exp();
    exp_q.push_back(mk(1, 0, 0));
    for (int r = 0; r < 1024; r++) begin
      bit hit = 0;
      int lo = 255, hi = 0;
      for (int w = 0; w < 8; w++)
        if (live(w) && r >= ac_ys[w] && r <= ac_ye[w]) begin
          hit = 1;
          if (ac_xs[w] < lo) lo = ac_xs[w];
          if (ac_xe[w] > hi) hi = ac_xe[w];
        end
      if (hit && kp(ac_sub, r)) begin
        exp_q.push_back(mk(2, r, 0));
        for (int c = lo; c <= hi; c++) begin
          bit cv = 0;
          for (int w = 0; w < 8; w++)
            if (live(w) && r >= ac_ys[w] && r <= ac_ye[w] && c >= ac_xs[w] && c <= ac_xe[w])
              cv = 1;
          if (cv && kp(ac_sub, c)) exp_q.push_back(mk(3, r, c));
        end
        exp_q.push_back(mk(4, r, 0));
      end
    end
    exp_q.push_back(mk(5, 0, 0));
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_win(int i, int en, int xs, int xe, int ys, int ye);
    wr({1'b0, 3'(i), 2'd0}, {16'd0, 8'(xe), 8'(xs)});
    wr({1'b0, 3'(i), 2'd1}, {6'd0, 10'(ye), 6'd0, 10'(ys)});
    wr({1'b0, 3'(i), 2'd2}, {31'd0, 1'(en)});
    wr({1'b0, 3'(i), 2'd3}, 32'hFFFF_FFFF);  // ignored field
    sh_en[i] = en; sh_xs[i] = xs; sh_xe[i] = xe; sh_ys[i] = ys; sh_ye[i] = ye;
  endtask

  task automatic set_ctl(int sub, int gain);
    wr(6'h20, {20'd0, 4'(gain), 6'd0, 2'(sub)});
    sh_sub = (sub == 3) ? 0 : sub; sh_gain = gain;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 8; i++) set_win(i, 0, 0, 0, 0, 0);
  endtask

  task automatic launch();
    for (int i = 0; i < 8; i++) begin
      ac_en[i] = sh_en[i]; ac_xs[i] = sh_xs[i]; ac_xe[i] = sh_xe[i];
      ac_ys[i] = sh_ys[i]; ac_ye[i] = sh_ye[i];
    end
    ac_sub = sh_sub; ac_gain = sh_gain;
    build_exp();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(frame_start_o == 1'b1, "R3 frame start after start", frame_start_o, 1);
    chk(busy_o == 1'b1, "R3 busy at frame start", busy_o, 1);
  endtask

  task automatic finish_frame(string tag);
    int guard = 0;
    while (busy_o && guard < 50000) begin
      @(negedge clk_i); guard++;
    end
    chk(!busy_o, "R3 busy clears", busy_o, 0);
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    chk(gain_o == 4'(ac_gain), "R9 gain from active bank", gain_o, ac_gain);
  endtask

  // scoreboard monitor
  logic [4:0] ev;
  bit   [20:0] obs, e;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      ev = {frame_start_o, line_start_o, rd_o, line_end_o, frame_end_o};
      if (ev != 0) begin
        chk($countones(ev) == 1 && busy_o, "R11 single event while busy", ev, 0);
        if (frame_start_o)      obs = mk(1, 0, 0);
        else if (line_start_o)  obs = mk(2, row_o, 0);
        else if (rd_o)          obs = mk(3, row_o, col_o);
        else if (line_end_o)    obs = mk(4, row_o, 0);
        else                    obs = mk(5, 0, 0);
        if (exp_q.size() == 0) chk(1'b0, "R4/R10 unexpected event", obs, 0);
        else begin
          e = exp_q.pop_front();
          chk(obs == e, "R4/R5/R6/R7/R12 event stream", obs, e);
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      sh_en[i] = 0; sh_xs[i] = 0; sh_xe[i] = 0; sh_ys[i] = 0; sh_ye[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk({busy_o, rd_o, frame_start_o, line_start_o, line_end_o, frame_end_o} == 0,
        "R1 outputs idle in reset", busy_o, 0);
    chk(gain_o == 0, "R1 gain reset", gain_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o, "R1 idle after reset", busy_o, 0);

    // R2 R4 single window
    set_ctl(0, 3);
    set_win(0, 1, 2, 4, 5, 7);
    launch(); finish_frame("R4 single window");

    // R5 overlapping rows, disjoint columns
    set_win(1, 1, 10, 11, 6, 9);
    launch(); finish_frame("R5 union of two windows");

    // R6 read-1-skip-1
    set_win(1, 0, 0, 0, 0, 0);
    set_win(0, 1, 1, 6, 3, 8);
    set_ctl(1, 4);
    launch(); finish_frame("R6 read-1-skip-1");

    // R6 read-2-skip-2
    set_win(0, 1, 0, 9, 0, 9);
    set_ctl(2, 5);
    launch(); finish_frame("R6 read-2-skip-2");

    // R2 mode 3 behaves as full
    set_ctl(3, 6);
    launch(); finish_frame("R2 mode 3 as full");

    // R8 no window
    clear_all();
    launch();
    @(negedge clk_i);
    chk(frame_end_o == 1'b1, "R8 frame end right after frame start", frame_end_o, 1);
    finish_frame("R8 empty frame");

    // R7 malformed windows
    set_ctl(0, 1);
    set_win(0, 1, 5, 3, 0, 4);
    set_win(1, 1, 150, 160, 0, 2);
    set_win(2, 1, 0, 2, 9, 2);
    set_win(3, 1, 0, 0, 0, 0);
    launch(); finish_frame("R7 malformed windows ignored");

    // R12 far corner, with R5 column union
    clear_all();
    set_win(0, 1, 158, 159, 1022, 1023);
    set_win(1, 1, 157, 158, 1023, 1023);
    launch(); finish_frame("R12 last row and group");

    // R9 R10 writes and start during a frame
    clear_all();
    set_ctl(0, 3);
    set_win(0, 1, 0, 3, 0, 20);
    launch();
    repeat (5) @(negedge clk_i);
    set_ctl(2, 9);
    set_win(0, 1, 4, 6, 2, 3);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 still in first frame", busy_o, 1);
    chk(gain_o == 4'd3, "R9 gain unchanged mid-frame", gain_o, 3);
    finish_frame("R9/R10 frame unaffected, no extra frame");
    launch(); finish_frame("R9 new settings next frame");
    chk(gain_o == 4'd9, "R9 new gain applied", gain_o, 9);

    // all eight windows
    set_ctl(0, 2);
    for (int i = 0; i < 8; i++) set_win(i, 1, i * 4, i * 4 + 2, i * 3, i * 3 + 4);
    launch(); finish_frame("R5 eight windows");

    done = 1;
    summary();
    $finish;
  end
endmodule